// File: doc/BRIEF.md
# Arithmetic Right Shift Unit with Flags

This unit executes a sign-preserving right shift on a byte, word or doubleword operand and produces the new status flags in the same step. It recognises the six opcode bytes of the shift family, but only when the ModRM reg field equals 7. From the opcode it takes the operand size and the source of the shift count. The count can be a fixed one, the low byte of the count register (CL), or an immediate byte.

Each accepted request is registered once. The shifted value, the flags and a flag-write enable appear on the outputs one clock after the request. A flag left untouched by the shift is presented as the incoming value, so the consumer can always write back the outputs whenever the flag-write enable is high.

Top module: `sar_unit`

## Requirements
- R1: Opcodes 0xD0/0xD1 (count fixed at one), 0xD2/0xD3 (count from `cl_count`) and 0xC0/0xC1 (count from `imm_count`) are accepted only with `modrm_reg` = 7, and then `out_hit` is 1. Opcode bit 0 = 0 selects 8 bits. Opcode bit 0 = 1 selects 32 bits when `wide_is_32` = 1 and 16 bits otherwise. Any other combination gives `out_hit` = 0 and is handled as an effective count of 0.
- R2: Each vacated high-order bit of the result is filled with the sign bit of the operand at the selected size.
- R3: Only bits [4:0] of the count are used, so the effective count is the count modulo 32.
- R4: When the effective count is not 0, `out_cf` is the last bit shifted out of the low end.
- R5: When the effective count is exactly 1, `out_of` is 0.
- R6: When the effective count is not 1, `out_of` equals `of_in`.
- R7: When the effective count is not 0, `out_sf` is the top bit of the result at the selected size, and `out_zf` is 1 exactly when the result at that size is zero.
- R8: When the effective count is not 0, `out_pf` is 1 exactly when bits [7:0] of the result hold an even number of ones.
- R9: `out_af` always equals `af_in`.
- R10: With an effective count of 0, the result is the operand at the selected size, every flag output equals its input, and `out_flag_we` is 0. Otherwise `out_flag_we` is 1.
- R11: For 8- and 16-bit operands whose effective count is at least the operand width, every result bit equals the sign bit, and so does `out_cf`.
- R12: All outputs are registered. `out_valid` follows `in_valid` by one clock, and reset clears every output to 0.
- R13: Result bits above the selected operand size are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present this cycle |
| opcode | input | 8 | Primary opcode byte |
| modrm_reg | input | 3 | ModRM reg field |
| wide_is_32 | input | 1 | Wide forms use 32 bits (else 16) |
| operand | input | 32 | Value to shift |
| cl_count | input | 8 | Count register byte |
| imm_count | input | 8 | Immediate count byte |
| cf_in | input | 1 | Current carry flag |
| of_in | input | 1 | Current overflow flag |
| sf_in | input | 1 | Current sign flag |
| zf_in | input | 1 | Current zero flag |
| pf_in | input | 1 | Current parity flag |
| af_in | input | 1 | Current auxiliary-carry flag |
| out_valid | output | 1 | Result present |
| out_hit | output | 1 | Opcode and reg field recognised |
| result | output | 32 | Shifted value, zero above the size |
| out_cf | output | 1 | New carry flag |
| out_of | output | 1 | New overflow flag |
| out_sf | output | 1 | New sign flag |
| out_zf | output | 1 | New zero flag |
| out_pf | output | 1 | New parity flag |
| out_af | output | 1 | Auxiliary-carry flag (passed through) |
| out_flag_we | output | 1 | Flags to be written |

## Verification
Every output belongs to the request accepted at the previous rising edge, so the whole result is due exactly one clock after its stimulus. The driver applies each request at a falling edge and queues the expected outcome, computed by a bit-serial reference model. The monitor compares at each falling edge where `out_valid` is high, half a clock after the registering edge. A valid output that appears with nothing queued is reported as a latency fault.

// File: rtl/sar_pkg.sv
package sar_pkg;
    typedef enum logic [1:0] {SZ_8, SZ_16, SZ_32} opsize_e;
    typedef enum logic [1:0] {CNT_ONE, CNT_REG, CNT_IMM} cntsrc_e;
    typedef struct packed {
        logic cf;
        logic of;
        logic sf;
        logic zf;
        logic pf;
        logic af;
    } flags_t;
endpackage

// File: rtl/sar_decode.sv
module sar_decode
    import sar_pkg::*;
(
    input  logic [7:0] opcode,
    input  logic [2:0] modrm_reg,
    input  logic       wide_is_32,
    output logic       hit,
    output opsize_e    size,
    output cntsrc_e    src
);
    localparam logic [2:0] REG_SEL = 3'd7;

    logic form_ok;

    always_comb begin
        form_ok = 1'b1;
        src     = CNT_ONE;
        case (opcode[7:1])
            7'h68:   src = CNT_ONE;   // D0 / D1
            7'h69:   src = CNT_REG;   // D2 / D3
            7'h60:   src = CNT_IMM;   // C0 / C1
            default: form_ok = 1'b0;
        endcase
        hit = form_ok && (modrm_reg == REG_SEL);
        if (!opcode[0])
            size = SZ_8;
        else if (wide_is_32)
            size = SZ_32;
        else
            size = SZ_16;
    end
endmodule

// File: rtl/sar_count.sv
module sar_count
    import sar_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int SH_W  = 5
) (
    input  cntsrc_e          src,
    input  logic [CNT_W-1:0] cl_count,
    input  logic [CNT_W-1:0] imm_count,
    output logic [SH_W-1:0]  eff
);
    logic [CNT_W-1:0] raw;

    always_comb begin
        unique case (src)
            CNT_REG: raw = cl_count;
            CNT_IMM: raw = imm_count;
            default: raw = CNT_W'(1);
        endcase
        eff = raw[SH_W-1:0];   // modulo 2**SH_W
    end
endmodule

// File: rtl/sar_core.sv
module sar_core
    import sar_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int SH_W   = 5
) (
    input  logic [DATA_W-1:0] operand,
    input  opsize_e           size,
    input  logic [SH_W-1:0]   eff,
    input  flags_t            flags_in,
    output logic [DATA_W-1:0] result,
    output flags_t            flags_out,
    output logic              flag_we
);
    logic [DATA_W-1:0]        ext;
    logic signed [DATA_W:0]   padded;
    logic signed [DATA_W:0]   shifted;
    logic [DATA_W-1:0]        raw;
    logic                     msb;

    always_comb begin
        unique case (size)
            SZ_8:    ext = {{(DATA_W-8){operand[7]}}, operand[7:0]};
            SZ_16:   ext = {{(DATA_W-16){operand[15]}}, operand[15:0]};
            default: ext = operand;
        endcase
        // extra low bit catches the last bit shifted out
        padded  = {ext, 1'b0};
        shifted = padded >>> eff;
        raw     = shifted[DATA_W:1];
        unique case (size)
            SZ_8: begin
                result = {{(DATA_W-8){1'b0}}, raw[7:0]};
                msb    = raw[7];
            end
            SZ_16: begin
                result = {{(DATA_W-16){1'b0}}, raw[15:0]};
                msb    = raw[15];
            end
            default: begin
                result = raw;
                msb    = raw[DATA_W-1];
            end
        endcase
        flag_we   = (eff != '0);
        flags_out = flags_in;
        if (flag_we) begin
            flags_out.cf = shifted[0];
            flags_out.sf = msb;
            flags_out.zf = (result == '0);
            flags_out.pf = ~^result[7:0];
            if (eff == SH_W'(1))
                flags_out.of = 1'b0;
        end
    end
endmodule

// File: rtl/sar_unit.sv
module sar_unit
    import sar_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [7:0]        opcode,
    input  logic [2:0]        modrm_reg,
    input  logic              wide_is_32,
    input  logic [DATA_W-1:0] operand,
    input  logic [CNT_W-1:0]  cl_count,
    input  logic [CNT_W-1:0]  imm_count,
    input  logic              cf_in,
    input  logic              of_in,
    input  logic              sf_in,
    input  logic              zf_in,
    input  logic              pf_in,
    input  logic              af_in,
    output logic              out_valid,
    output logic              out_hit,
    output logic [DATA_W-1:0] result,
    output logic              out_cf,
    output logic              out_of,
    output logic              out_sf,
    output logic              out_zf,
    output logic              out_pf,
    output logic              out_af,
    output logic              out_flag_we
);
    localparam int SH_W = $clog2(DATA_W);

    logic              hit_d;
    opsize_e           size_d;
    cntsrc_e           src_d;
    logic [SH_W-1:0]   eff_d;
    logic [SH_W-1:0]   eff_g;
    flags_t            flags_cur;
    flags_t            flags_nxt;
    logic [DATA_W-1:0] res_nxt;
    logic              we_nxt;
    flags_t            flags_q;

    sar_decode u_decode (
        .opcode    (opcode),
        .modrm_reg (modrm_reg),
        .wide_is_32(wide_is_32),
        .hit       (hit_d),
        .size      (size_d),
        .src       (src_d)
    );

    sar_count #(.CNT_W(CNT_W), .SH_W(SH_W)) u_count (
        .src      (src_d),
        .cl_count (cl_count),
        .imm_count(imm_count),
        .eff      (eff_d)
    );

    assign eff_g     = hit_d ? eff_d : '0;
    assign flags_cur = '{cf: cf_in, of: of_in, sf: sf_in, zf: zf_in,
                         pf: pf_in, af: af_in};

    sar_core #(.DATA_W(DATA_W), .SH_W(SH_W)) u_core (
        .operand  (operand),
        .size     (size_d),
        .eff      (eff_g),
        .flags_in (flags_cur),
        .result   (res_nxt),
        .flags_out(flags_nxt),
        .flag_we  (we_nxt)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            out_hit     <= 1'b0;
            result      <= '0;
            flags_q     <= '0;
            out_flag_we <= 1'b0;
        end else begin
            out_valid   <= in_valid;
            out_hit     <= in_valid && hit_d;
            result      <= in_valid ? res_nxt : '0;
            flags_q     <= in_valid ? flags_nxt : '0;
            out_flag_we <= in_valid && we_nxt;
        end
    end

    assign out_cf = flags_q.cf;
    assign out_of = flags_q.of;
    assign out_sf = flags_q.sf;
    assign out_zf = flags_q.zf;
    assign out_pf = flags_q.pf;
    assign out_af = flags_q.af;

    assert_latency_R12: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid && !out_flag_we);
    assert_nohit_R1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !hit_d |=> !out_hit && !out_flag_we);
    assert_of_cleared_R5: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && hit_d && eff_d == SH_W'(1) |=> !out_of && out_flag_we);
    assert_of_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && eff_g != SH_W'(1) |=> out_of == $past(of_in));
    assert_af_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_af == $past(af_in));
    assert_upper_zero_R13: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && size_d == SZ_8 |=> result[DATA_W-1:8] == '0);
endmodule

// File: tb/sar_unit_tb.sv
module sar_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  opcode = '0;
    logic [2:0]  modrm_reg = '0;
    logic        wide_is_32 = 1'b0;
    logic [31:0] operand = '0;
    logic [7:0]  cl_count = '0;
    logic [7:0]  imm_count = '0;
    logic        cf_in = 0, of_in = 0, sf_in = 0, zf_in = 0, pf_in = 0, af_in = 0;
    logic        out_valid, out_hit, out_cf, out_of, out_sf, out_zf, out_pf, out_af;
    logic        out_flag_we;
    logic [31:0] result;

    int checks = 0;
    int failures = 0;
    logic monitor_on = 1'b0;

    typedef struct {
        logic [31:0] res;
        logic [5:0]  fl;   // {cf,of,sf,zf,pf,af}
        logic        hit;
        logic        we;
        string       tag;
    } exp_t;
    exp_t sb[$];

    always #5 clk = ~clk;

    sar_unit u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
        .modrm_reg(modrm_reg), .wide_is_32(wide_is_32), .operand(operand),
        .cl_count(cl_count), .imm_count(imm_count),
        .cf_in(cf_in), .of_in(of_in), .sf_in(sf_in), .zf_in(zf_in),
        .pf_in(pf_in), .af_in(af_in),
        .out_valid(out_valid), .out_hit(out_hit), .result(result),
        .out_cf(out_cf), .out_of(out_of), .out_sf(out_sf), .out_zf(out_zf),
        .out_pf(out_pf), .out_af(out_af), .out_flag_we(out_flag_we)
    );

    function automatic exp_t model(input logic [7:0] opc, input logic [2:0] rg,
                                   input logic wd, input logic [31:0] op,
                                   input logic [7:0] cl, input logic [7:0] im,
                                   input logic [5:0] fl);
        exp_t e;
        int w;
        int n;
        logic [31:0] v;
        logic sgn, c;
        logic [7:0] cnt;
        e.hit = (rg == 3'd7) && (opc == 8'hD0 || opc == 8'hD1 || opc == 8'hD2 ||
                opc == 8'hD3 || opc == 8'hC0 || opc == 8'hC1);
        w = !opc[0] ? 8 : (wd ? 32 : 16);
        if (opc[7:1] == 7'h69) cnt = cl;
        else if (opc[7:1] == 7'h60) cnt = im;
        else cnt = 8'd1;
        n = e.hit ? int'(cnt % 8'd32) : 0;
        v = (w == 32) ? op : (op & ((32'd1 << w) - 32'd1));
        sgn = v[w-1];
        c = 1'b0;
        for (int i = 0; i < n; i++) begin
            c = v[0];
            v = v >> 1;
            if (sgn) v = v | (32'd1 << (w - 1));
        end
        e.res = v;
        e.fl = fl;
        e.we = (n != 0);
        if (n != 0) begin
            e.fl[5] = c;
            if (n == 1) e.fl[4] = 1'b0;
            e.fl[3] = v[w-1];
            e.fl[2] = (v == 32'd0);
            e.fl[1] = ~^v[7:0];
        end
        return e;
    endfunction

    task automatic send(input logic [7:0] opc, input logic [2:0] rg, input logic wd,
                        input logic [31:0] op, input logic [7:0] cl,
                        input logic [7:0] im, input logic [5:0] fl, input string tag);
        exp_t e;
        @(negedge clk);
        in_valid = 1'b1; opcode = opc; modrm_reg = rg; wide_is_32 = wd;
        operand = op; cl_count = cl; imm_count = im;
        {cf_in, of_in, sf_in, zf_in, pf_in, af_in} = fl;
        e = model(opc, rg, wd, op, cl, im, fl);
        e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    always @(negedge clk) begin
        if (monitor_on && out_valid) begin
            checks++;
            if (sb.size() == 0) begin
                failures++;
                $display("FAIL R12 valid output with nothing pending: actual out_valid=1 expected 0");
            end else begin
                exp_t e;
                e = sb.pop_front();
                if (result !== e.res || out_hit !== e.hit || out_flag_we !== e.we ||
                    {out_cf, out_of, out_sf, out_zf, out_pf, out_af} !== e.fl) begin
                    failures++;
                    $display("FAIL %s actual res=%h hit=%b we=%b fl=%b expected res=%h hit=%b we=%b fl=%b",
                             e.tag, result, out_hit, out_flag_we,
                             {out_cf, out_of, out_sf, out_zf, out_pf, out_af},
                             e.res, e.hit, e.we, e.fl);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired: actual hung expected done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;   // R12 reset state
        if (out_valid !== 1'b0 || result !== 32'd0 || out_flag_we !== 1'b0) begin
            failures++;
            $display("FAIL R12 reset state: actual valid=%b res=%h we=%b expected 0 0 0",
                     out_valid, result, out_flag_we);
        end
        rst_n = 1'b1;
        monitor_on = 1'b1;
        send(8'hD1, 3'd7, 1'b1, 32'h8000_0001, 8'd0, 8'd0, 6'b010000, "R5");
        send(8'hD3, 3'd7, 1'b1, 32'h8000_00F0, 8'd4, 8'd0, 6'b000000, "R2");
        send(8'hD2, 3'd7, 1'b0, 32'hFFFF_FF85, 8'd3, 8'd0, 6'b000000, "R4");
        send(8'hC1, 3'd7, 1'b0, 32'h1234_7FF8, 8'd0, 8'h24, 6'b000000, "R3");
        send(8'hD2, 3'd7, 1'b0, 32'hABCD_EF5A, 8'h20, 8'd0, 6'b101011, "R10");
        send(8'hC0, 3'd7, 1'b0, 32'h0000_0080, 8'd0, 8'd12, 6'b000000, "R11");
        send(8'hC1, 3'd7, 1'b0, 32'h0000_4000, 8'd0, 8'd20, 6'b100000, "R11_R7");
        send(8'hD3, 3'd7, 1'b1, 32'h8000_0000, 8'd31, 8'd0, 6'b100000, "R2");
        idle();
        send(8'hD1, 3'd6, 1'b1, 32'h1234_5678, 8'd0, 8'd0, 6'b110101, "R1");
        send(8'hC0, 3'd7, 1'b1, 32'hFFFF_FF06, 8'd0, 8'd2, 6'b000010, "R8");
        send(8'hC0, 3'd7, 1'b0, 32'h0000_00C6, 8'd0, 8'd1, 6'b000000, "R8");
        send(8'hD3, 3'd7, 1'b1, 32'h7000_0004, 8'd2, 8'd0, 6'b010001, "R6_R9");
        send(8'hD1, 3'd7, 1'b0, 32'hFFFF_8001, 8'd0, 8'd0, 6'b000000, "R13");
        send(8'h90, 3'd7, 1'b1, 32'h0000_0040, 8'd3, 8'd0, 6'b001100, "R1");
        idle();
        idle();
        for (int k = 0; k < 40; k++) begin
            logic [7:0] opc;
            case ($urandom % 6)
                0: opc = 8'hD0; 1: opc = 8'hD1; 2: opc = 8'hD2;
                3: opc = 8'hD3; 4: opc = 8'hC0; default: opc = 8'hC1;
            endcase
            send(opc, 3'(($urandom % 4 == 0) ? $urandom : 7), 1'($urandom),
                 $urandom, 8'($urandom), 8'($urandom), 6'($urandom), "R7");
        end
        idle();
        repeat (3) @(negedge clk);
        checks++;   // R12 every request answered
        if (sb.size() != 0) begin
            failures++;
            $display("FAIL R12 pending results: actual %0d expected 0", sb.size());
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule